// File: doc/BRIEF.md
# Bus Master Transaction Sequencer

This block is the master-side engine that a local client uses to reach a shared on-chip peripheral bus. The client hands over one request at a time through a valid/ready handshake. A request is a single transfer of a byte, half-word or word, a block of 2, 4 or 8 words, or an atomic read-modify-write. The sequencer requests the bus, waits for the grant and drives one address phase. It then runs the data phases and returns read data beat by beat, followed by a one-cycle completion pulse.

Slaves answer each data phase with ready, wait (neither ready nor busy) or busy. A busy answer on the first data phase makes the sequencer give up the bus for exactly one cycle and then ask again, for as many rounds as the slave stays busy. If the grant is still parked on this master in that released cycle, the retry starts its address phase at once. An atomic operation is a read followed by a write to the same address. The write value comes from the read value and the client's operand, using one of four modify operations. A lock output stays high from the read request to the end of the write, so the pair is never split by another master.

Requests that are badly formed are refused without touching the bus.

Top module: `bmx_bus_master`

## Requirements
- R1: After reset `req_ready` is 1 and `bus_req`, `bus_lock`, `bus_aval`, `rsp_done`, `rsp_err` and `rsp_beat` are all 0.
- R2: A single transfer (`req_kind`=0) moves one item whose size is given by `req_size` (0 byte, 1 half-word, 2 word). The item is right-aligned on `bus_wdata`/`bus_rdata` and sits at byte offset `addr[1:0]` of the addressed word. A read returns the item on `rsp_rdata` with a one-cycle `rsp_beat`.
- R3: A block transfer (`req_kind`=1) is always word sized. Its length code `req_blen` means 0 = 2, 1 = 4 and 2 = 8 words. It uses one address phase, shown on `bus_burst` as `req_blen`+1 while a single transfer shows 0, and then one data phase per word. During each data phase `bus_addr` shows start + 4*i. A block write takes one `blk_wdata` word per completed beat and pulses `blk_wtake` for it.
- R4: A request is refused when any of these holds: kind 3; size 3 on a non-block request; length code 3 on a block; a half-word at an odd address; a word at an address not a multiple of 4; a block whose start address is not a multiple of its total byte length. A refused request raises `rsp_done` and `rsp_err` together in the cycle after acceptance, and `bus_req` stays low.
- R5: An atomic request (`req_kind`=2) reads the item and then writes the same address. The written value is chosen by `req_mod`: 0 gives the operand, 1 gives read OR operand, 2 gives read AND NOT operand, and 3 gives read + operand. The write's address phase falls in the cycle right after the read data phase completes. The read value is returned on `rsp_rdata`.
- R6: For an atomic request `bus_lock` rises together with the first bus request. It stays high through both halves and any busy rounds, and falls in the same cycle that `rsp_done` rises.
- R7: A busy answer on the first data phase of a transfer is followed by one cycle with `bus_req` low, after which the transfer requests the bus and drives its address phase again. Each further busy answer repeats this.
- R8: When the grant is high during the released cycle, the address phase follows in the next cycle. One busy round then costs 3 extra cycles, against 4 when the grant must be requested again.
- R9: A data phase in which the slave shows neither ready nor busy is a wait state. The beat stays pending and nothing is lost.
- R10: `rsp_done` is a single-cycle pulse per request, and `req_ready` is high only while no request is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Client request valid |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_kind | input | 2 | 0 single, 1 block, 2 atomic, 3 illegal |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 illegal |
| req_write | input | 1 | Write when 1 (single and block) |
| req_blen | input | 2 | Block length code: 0=2, 1=4, 2=8 words |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Single write data or atomic operand |
| req_mod | input | 2 | Atomic modify operation |
| blk_wdata | input | 32 | Current block write word |
| blk_wtake | output | 1 | Block write word consumed this cycle |
| rsp_beat | output | 1 | Read data valid pulse |
| rsp_rdata | output | 32 | Read data |
| rsp_done | output | 1 | Request complete pulse |
| rsp_err | output | 1 | Request refused (with rsp_done) |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_lock | output | 1 | Bus held for an atomic pair |
| bus_aval | output | 1 | Address phase |
| bus_addr | output | AW | Address phase / current beat address |
| bus_write | output | 1 | Transfer direction |
| bus_size | output | 2 | Item size |
| bus_burst | output | 2 | 0 single, 1..3 block of 2/4/8 words |
| bus_wdata | output | 32 | Write data in data phases |
| bus_rdata | input | 32 | Read data from slave |
| bus_rdy | input | 1 | Slave completes the data phase |
| bus_busy | input | 1 | Slave busy on first data phase |

## Verification
The bench builds the sequencer with the default 16-bit address. It keeps all traffic inside a 64-word window that a behavioural slave and a separate reference memory both cover, so every block length, byte lane and alignment case can be reached. The slave can be told to answer busy a set number of times on either half of a transfer, to insert wait states, and to keep the grant parked or not. This lets the bench measure the exact cycle cost of a retry under both grant policies and hold the lock check across retries on both atomic halves.

// File: rtl/bmx_pkg.sv
package bmx_pkg;
    localparam int DATA_W    = 32;
    localparam int MAX_BEATS = 8;
    localparam int BEAT_W    = $clog2(MAX_BEATS);

    typedef enum logic [1:0] {K_SINGLE = 2'd0, K_BLOCK = 2'd1, K_ATOMIC = 2'd2, K_BAD = 2'd3} kind_e;
    typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_BAD = 2'd3} size_e;
    typedef enum logic [1:0] {M_SWAP = 2'd0, M_SET = 2'd1, M_CLR = 2'd2, M_ADD = 2'd3} mod_e;
    typedef enum logic [2:0] {S_IDLE, S_ARB, S_ADDR, S_DATA, S_GAP} st_e;
endpackage

// File: rtl/bmx_req_check.sv
module bmx_req_check
    import bmx_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [1:0]    kind,
    input  logic [1:0]    size,
    input  logic [1:0]    blen,
    input  logic [AW-1:0] addr,
    output logic          bad
);
    logic [AW-1:0] blk_mask;
    logic          misal;

    always_comb begin
        blk_mask = (AW'(8) << blen) - AW'(1);
        misal    = 1'b0;
        if (kind == K_BLOCK) begin
            misal = (addr & blk_mask) != '0;
        end else if (size == SZ_HALF) begin
            misal = addr[0];
        end else if (size == SZ_WORD) begin
            misal = addr[1:0] != 2'b00;
        end
        bad = (kind == K_BAD)
            || (kind != K_BLOCK && size == SZ_BAD)
            || (kind == K_BLOCK && blen == 2'd3)
            || misal;
    end
endmodule

// File: rtl/bmx_beat_gen.sv
module bmx_beat_gen
    import bmx_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0]     base,
    input  logic [BEAT_W-1:0] beat,
    input  logic [1:0]        blen,
    input  logic              is_block,
    output logic [AW-1:0]     beat_addr,
    output logic              last
);
    logic [BEAT_W-1:0] final_idx;

    always_comb begin
        final_idx = '0;
        if (is_block) begin
            unique case (blen)
                2'd0:    final_idx = BEAT_W'(1);
                2'd1:    final_idx = BEAT_W'(3);
                default: final_idx = BEAT_W'(MAX_BEATS - 1);
            endcase
        end
        beat_addr = base + (AW'(beat) << 2);
        last      = beat == final_idx;
    end
endmodule

// File: rtl/bmx_modify.sv
module bmx_modify
    import bmx_pkg::*;
(
    input  logic [1:0]        op,
    input  logic [DATA_W-1:0] rd,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] result
);
    always_comb begin
        unique case (mod_e'(op))
            M_SWAP:  result = operand;
            M_SET:   result = rd | operand;
            M_CLR:   result = rd & ~operand;
            default: result = rd + operand;
        endcase
    end
endmodule

// File: rtl/bmx_bus_master.sv
module bmx_bus_master
    import bmx_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [1:0]        req_blen,
    input  logic [AW-1:0]     req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_mod,
    input  logic [DATA_W-1:0] blk_wdata,
    output logic              blk_wtake,
    output logic              rsp_beat,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_lock,
    output logic              bus_aval,
    output logic [AW-1:0]     bus_addr,
    output logic              bus_write,
    output logic [1:0]        bus_size,
    output logic [1:0]        bus_burst,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_rdy,
    input  logic              bus_busy
);
    typedef struct packed {
        st_e               st;
        kind_e             kind;
        logic              wr;
        size_e             size;
        logic [1:0]        blen;
        logic [AW-1:0]     addr;
        logic [DATA_W-1:0] wdata;
        logic [1:0]        mod;
        logic [BEAT_W-1:0] beat;
        logic              phase;
        logic              lock;
        logic              done;
        logic              err;
        logic              beat_v;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    ctl_t d, q;

    logic              req_bad;
    logic [AW-1:0]     beat_addr;
    logic              last;
    logic [DATA_W-1:0] mod_res;
    logic              busy_hit;
    logic              beat_ok;

    bmx_req_check #(.AW(AW)) u_check (
        .kind (req_kind),
        .size (req_size),
        .blen (req_blen),
        .addr (req_addr),
        .bad  (req_bad)
    );

    bmx_beat_gen #(.AW(AW)) u_beat (
        .base      (q.addr),
        .beat      (q.beat),
        .blen      (q.blen),
        .is_block  (q.kind == K_BLOCK),
        .beat_addr (beat_addr),
        .last      (last)
    );

    bmx_modify u_mod (
        .op      (q.mod),
        .rd      (bus_rdata),
        .operand (q.wdata),
        .result  (mod_res)
    );

    // Busy only counts before the first beat of a transfer; later beats may only wait.
    assign busy_hit = (q.st == S_DATA) && bus_busy && (q.beat == '0);
    assign beat_ok  = (q.st == S_DATA) && bus_rdy && !busy_hit;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.err    = 1'b0;
        d.beat_v = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    if (req_bad) begin
                        d.done = 1'b1;
                        d.err  = 1'b1;
                    end else begin
                        d.st    = S_ARB;
                        d.kind  = kind_e'(req_kind);
                        d.wr    = (kind_e'(req_kind) == K_ATOMIC) ? 1'b0 : req_write;
                        d.size  = (kind_e'(req_kind) == K_BLOCK) ? SZ_WORD : size_e'(req_size);
                        d.blen  = req_blen;
                        d.addr  = req_addr;
                        d.wdata = req_wdata;
                        d.mod   = req_mod;
                        d.beat  = '0;
                        d.phase = 1'b0;
                        d.lock  = kind_e'(req_kind) == K_ATOMIC;
                    end
                end
            end
            S_ARB: begin
                if (bus_gnt) d.st = S_ADDR;
            end
            S_ADDR: begin
                d.st   = S_DATA;
                d.beat = '0;
            end
            S_DATA: begin
                if (busy_hit) begin
                    d.st = S_GAP;
                end else if (beat_ok) begin
                    if (!q.wr) begin
                        d.beat_v = 1'b1;
                        d.rdata  = bus_rdata;
                    end
                    if (last) begin
                        if (q.kind == K_ATOMIC && !q.phase) begin
                            d.phase = 1'b1;
                            d.wr    = 1'b1;
                            d.wdata = mod_res;
                            d.st    = S_ADDR;
                        end else begin
                            d.st   = S_IDLE;
                            d.done = 1'b1;
                            d.lock = 1'b0;
                        end
                    end else begin
                        d.beat = q.beat + BEAT_W'(1);
                    end
                end
            end
            S_GAP: begin
                d.st = bus_gnt ? S_ADDR : S_ARB;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready = q.st == S_IDLE;
    assign bus_req   = (q.st == S_ARB) || (q.st == S_ADDR) || (q.st == S_DATA);
    assign bus_lock  = q.lock;
    assign bus_aval  = q.st == S_ADDR;
    assign bus_addr  = (q.st == S_DATA) ? beat_addr : q.addr;
    assign bus_write = q.wr;
    assign bus_size  = q.size;
    assign bus_burst = (q.kind == K_BLOCK) ? (q.blen + 2'd1) : 2'd0;
    assign bus_wdata = (q.kind == K_BLOCK) ? blk_wdata : q.wdata;
    assign blk_wtake = beat_ok && q.wr && (q.kind == K_BLOCK);
    assign rsp_beat  = q.beat_v;
    assign rsp_rdata = q.rdata;
    assign rsp_done  = q.done;
    assign rsp_err   = q.err;

    a_r1_ready_means_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!bus_req && !bus_aval && !bus_lock));

    a_r3_one_address_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_aval |=> !bus_aval);

    a_r4_refusal_off_bus: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_done && !bus_req));

    a_r5_write_half_next: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_DATA && q.kind == K_ATOMIC && !q.wr && bus_rdy && !bus_busy)
        |=> (bus_aval && bus_write));

    a_r6_lock_drops_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_lock) |-> rsp_done);

    a_r7_release_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_hit |=> !bus_req);

    a_r8_parked_regrant: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_GAP && bus_gnt) |=> bus_aval);

    a_r10_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
endmodule

// File: tb/bmx_bus_master_bench.sv
module bmx_bus_master_bench;
    localparam int AW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_kind = '0, req_size = '0, req_blen = '0, req_mod = '0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0, blk_wdata = '0, bus_rdata = '0;
    logic          blk_wtake, rsp_beat, rsp_done, rsp_err;
    logic [31:0]   rsp_rdata, bus_wdata;
    logic          bus_req, bus_lock, bus_aval, bus_write;
    logic          bus_gnt = 1'b0, bus_rdy = 1'b0, bus_busy = 1'b0;
    logic [AW-1:0] bus_addr;
    logic [1:0]    bus_size, bus_burst;

    bmx_bus_master #(.AW(AW)) u_bmx_bus_master (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_size(req_size), .req_write(req_write), .req_blen(req_blen),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mod(req_mod),
        .blk_wdata(blk_wdata), .blk_wtake(blk_wtake),
        .rsp_beat(rsp_beat), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .rsp_err(rsp_err),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_lock(bus_lock), .bus_aval(bus_aval),
        .bus_addr(bus_addr), .bus_write(bus_write), .bus_size(bus_size),
        .bus_burst(bus_burst), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rdy(bus_rdy), .bus_busy(bus_busy)
    );

    typedef struct {
        int addr; bit wr; int size; int nb; int burst; int busy; int waits;
    } xfer_t;

    xfer_t       xq[$];
    logic [31:0] exp_rd[$];
    logic [31:0] blk_wq[$];
    logic [31:0] ref_mem [0:63];
    logic [31:0] sl_mem  [0:63];

    int    checks = 0, errors = 0, cyc = 0;
    bit    park = 1'b0, done_seen = 1'b0, atom_on = 1'b0, err_op = 1'b0, exp_err = 1'b0;
    string cur_tag = "R2";

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] get_item(input logic [31:0] w, input int addr, input int size);
        int o = addr % 4;
        if (size == 0) return {24'b0, w[8*o +: 8]};
        if (size == 1) return {16'b0, w[8*o +: 16]};
        return w;
    endfunction

    function automatic logic [31:0] put_item(input logic [31:0] w, input int addr, input int size,
                                             input logic [31:0] v);
        logic [31:0] r = w;
        int o = addr % 4;
        if (size == 0) r[8*o +: 8] = v[7:0];
        else if (size == 1) r[8*o +: 16] = v[15:0];
        else r = v;
        return r;
    endfunction

    // behavioural slave and grant source, reacting on every falling edge
    int  s_beat = 0, s_wait = 0, s_busy = 0;
    bit  in_data = 1'b0, fresh = 1'b1, busy_prev = 1'b0, fire_w = 1'b0;
    xfer_t cur;

    always @(negedge clk) begin
        bus_rdy  = 1'b0;
        bus_busy = 1'b0;
        fire_w   = 1'b0;
        if (rst_n) begin
            if (busy_prev) chk(!bus_req, "R7 gap after busy", 32'(bus_req), 32'd0);
            busy_prev = 1'b0;
            if (bus_aval) begin
                chk(xq.size() > 0, "R3 unexpected address phase", 32'(xq.size()), 32'd1);
                if (xq.size() > 0) begin
                    cur = xq[0];
                    if (fresh) begin s_busy = cur.busy; fresh = 1'b0; end
                    chk(int'(bus_addr) == cur.addr, "R3 address phase addr", 32'(bus_addr), 32'(cur.addr));
                    chk(bus_write == cur.wr, "R5 direction", 32'(bus_write), 32'(cur.wr));
                    chk(int'(bus_burst) == cur.burst, "R3 burst code", 32'(bus_burst), 32'(cur.burst));
                    chk(int'(bus_size) == cur.size, "R2 size", 32'(bus_size), 32'(cur.size));
                    in_data = 1'b1; s_beat = 0; s_wait = cur.waits;
                end
            end else if (in_data) begin
                if (s_beat == 0 && s_busy > 0) begin
                    s_busy--; bus_busy = 1'b1; in_data = 1'b0; busy_prev = 1'b1;
                end else if (s_wait > 0) begin
                    s_wait--;
                end else begin
                    chk(int'(bus_addr) == cur.addr + 4*s_beat, "R3 beat address",
                        32'(bus_addr), 32'(cur.addr + 4*s_beat));
                    bus_rdy = 1'b1;
                    if (!cur.wr) bus_rdata = get_item(sl_mem[(cur.addr/4 + s_beat) % 64], cur.addr, cur.size);
                    else begin
                        fire_w = 1'b1;
                        if (cur.burst != 0 && blk_wq.size() > 0) blk_wdata = blk_wq[0];
                    end
                    s_beat++;
                    s_wait = cur.waits;
                    if (s_beat == cur.nb) begin
                        in_data = 1'b0; void'(xq.pop_front()); fresh = 1'b1;
                    end
                end
            end
        end
        bus_gnt = park || bus_req;
        #1;
        if (fire_w) begin
            sl_mem[(cur.addr/4 + s_beat - 1) % 64] =
                put_item(sl_mem[(cur.addr/4 + s_beat - 1) % 64], cur.addr, cur.size, bus_wdata);
            if (cur.burst != 0) begin
                chk(blk_wtake, "R3 block word taken", 32'(blk_wtake), 32'd1);
                if (blk_wq.size() > 0) void'(blk_wq.pop_front());
            end
        end
    end

    // response monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_beat) begin
                chk(exp_rd.size() > 0, {cur_tag, " extra read beat"}, 32'(exp_rd.size()), 32'd1);
                if (exp_rd.size() > 0) begin
                    chk(rsp_rdata == exp_rd[0], {cur_tag, " read data"}, rsp_rdata, exp_rd[0]);
                    void'(exp_rd.pop_front());
                end
            end
            if (err_op && bus_req) chk(1'b0, "R4 bus used by refused request", 32'd1, 32'd0);
            if (atom_on) begin
                if (rsp_done) begin
                    chk(!bus_lock, "R6 lock released at done", 32'(bus_lock), 32'd0);
                    atom_on = 1'b0;
                end else chk(bus_lock, "R6 lock held", 32'(bus_lock), 32'd1);
            end
            if (rsp_done) begin
                chk(rsp_err == exp_err, "R4 error flag", 32'(rsp_err), 32'(exp_err));
                done_seen = 1'b1;
            end
        end
    end

    task automatic do_op(input string tag, input int kind, input int size, input bit wr, input int blen,
                         input int addr, input logic [31:0] wd, input int md,
                         input int busy_a, input int busy_b, input int waits, output int lat);
        bit bad;
        int nb;
        logic [31:0] rd, res, v;
        bad = (kind == 3) || (kind != 1 && size == 3) || (kind == 1 && blen == 3)
           || (kind == 1 && (addr % (8 << blen)) != 0)
           || (kind != 1 && size == 1 && addr % 2 != 0)
           || (kind != 1 && size == 2 && addr % 4 != 0);
        if (!bad) begin
            if (kind == 0) begin
                xq.push_back('{addr, wr, size, 1, 0, busy_a, waits});
                if (wr) ref_mem[addr/4] = put_item(ref_mem[addr/4], addr, size, wd);
                else exp_rd.push_back(get_item(ref_mem[addr/4], addr, size));
            end else if (kind == 1) begin
                nb = 2 << blen;
                xq.push_back('{addr, wr, 2, nb, blen + 1, busy_a, waits});
                for (int i = 0; i < nb; i++) begin
                    if (wr) begin
                        v = wd ^ (32'h0101_0000 * i);
                        blk_wq.push_back(v);
                        ref_mem[addr/4 + i] = v;
                    end else exp_rd.push_back(ref_mem[addr/4 + i]);
                end
            end else begin
                rd = get_item(ref_mem[addr/4], addr, size);
                case (md)
                    0: res = wd;
                    1: res = rd | wd;
                    2: res = rd & ~wd;
                    default: res = rd + wd;
                endcase
                exp_rd.push_back(rd);
                ref_mem[addr/4] = put_item(ref_mem[addr/4], addr, size, res);
                xq.push_back('{addr, 1'b0, size, 1, 0, busy_a, waits});
                xq.push_back('{addr, 1'b1, size, 1, 0, busy_b, waits});
            end
        end
        cur_tag = tag;
        done_seen = 1'b0;
        exp_err = bad;
        @(negedge clk); #3;
        req_valid = 1'b1; req_kind = 2'(kind); req_size = 2'(size); req_write = wr;
        req_blen = 2'(blen); req_addr = AW'(addr); req_wdata = wd; req_mod = 2'(md);
        @(negedge clk); #3;
        req_valid = 1'b0;
        err_op = bad;
        atom_on = (kind == 2) && !bad;
        lat = 0;
        while (!done_seen) begin
            @(negedge clk); #3;
            lat++;
        end
        err_op = 1'b0;
        @(negedge clk); #3;
        chk(!rsp_done && req_ready, "R10 single done pulse, ready again", 32'({rsp_done, req_ready}), 32'b01);
        chk(xq.size() == 0 && exp_rd.size() == 0, {tag, " all transfers finished"},
            32'(xq.size() + exp_rd.size()), 32'd0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int l0, l1, l2, l3, l4, lx, mism;
        for (int i = 0; i < 64; i++) begin
            ref_mem[i] = 32'h1000_0011 + 32'h0103_0507 * i;
            sl_mem[i]  = ref_mem[i];
        end
        repeat (3) @(negedge clk);
        #3;
        // R1: state at reset
        chk(req_ready && !bus_req && !bus_lock && !bus_aval && !rsp_done && !rsp_err && !rsp_beat,
            "R1 reset outputs", 32'({req_ready, bus_req, bus_lock, bus_aval, rsp_done, rsp_err, rsp_beat}),
            32'b1000000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: single transfers
        do_op("R2", 0, 2, 1, 0, 'h10, 32'hDEAD_BEEF, 0, 0, 0, 0, lx);
        do_op("R2", 0, 2, 0, 0, 'h10, 32'h0, 0, 0, 0, 0, lx);
        do_op("R2", 0, 0, 1, 0, 'h13, 32'h0000_005A, 0, 0, 0, 0, lx);
        do_op("R2", 0, 0, 0, 0, 'h13, 32'h0, 0, 0, 0, 0, lx);
        do_op("R2", 0, 1, 1, 0, 'h22, 32'h0000_C3C3, 0, 0, 0, 0, lx);
        do_op("R2", 0, 1, 0, 0, 'h22, 32'h0, 0, 0, 0, 0, lx);

        // R3 / R9: blocks of each length, with wait states
        do_op("R3", 1, 2, 0, 1, 'h40, 32'h0, 0, 0, 0, 0, lx);
        do_op("R9", 1, 2, 1, 2, 'h80, 32'hA0B0_C0D0, 0, 0, 0, 1, lx);
        do_op("R3", 1, 2, 1, 0, 'h08, 32'h1234_5678, 0, 0, 0, 0, lx);
        do_op("R3", 1, 2, 0, 0, 'h08, 32'h0, 0, 0, 0, 0, lx);
        do_op("R3", 1, 2, 0, 2, 'h80, 32'h0, 0, 2, 0, 2, lx);

        // R4: refused requests
        do_op("R4", 1, 2, 0, 1, 'h48, 32'h0, 0, 0, 0, 0, lx);
        chk(lx == 0, "R4 refusal in next cycle", 32'(lx), 32'd0);
        do_op("R4", 0, 1, 0, 0, 'h01, 32'h0, 0, 0, 0, 0, lx);
        do_op("R4", 3, 2, 0, 0, 'h00, 32'h0, 0, 0, 0, 0, lx);
        do_op("R4", 1, 2, 0, 3, 'h00, 32'h0, 0, 0, 0, 0, lx);
        do_op("R4", 2, 3, 0, 0, 'h00, 32'h0, 0, 0, 0, 0, lx);

        // R5 / R6: atomic pairs, all modify codes, busy on both halves
        do_op("R5", 2, 2, 0, 0, 'h30, 32'hCAFE_F00D, 0, 0, 0, 0, lx);
        do_op("R5", 2, 2, 0, 0, 'h34, 32'h0000_FF00, 1, 0, 0, 0, lx);
        do_op("R5", 2, 2, 0, 0, 'h38, 32'h0F0F_0F0F, 2, 0, 0, 0, lx);
        do_op("R5", 2, 0, 0, 0, 'h3D, 32'h0000_0001, 3, 0, 0, 0, lx);
        do_op("R6", 2, 2, 0, 0, 'h2C, 32'h0000_0003, 3, 2, 1, 0, lx);
        park = 1'b1;
        do_op("R6", 2, 1, 0, 0, 'h2A, 32'h0000_8001, 1, 1, 2, 1, lx);

        // R7 / R8 / R9: retry cost under both grant policies, and wait-state cost
        do_op("R8", 0, 2, 0, 0, 'h50, 32'h0, 0, 0, 0, 0, l0);
        do_op("R8", 0, 2, 0, 0, 'h50, 32'h0, 0, 1, 0, 0, l1);
        do_op("R9", 0, 2, 0, 0, 'h50, 32'h0, 0, 0, 0, 2, l4);
        chk(l1 - l0 == 3, "R8 parked retry cost", 32'(l1 - l0), 32'd3);
        chk(l4 - l0 == 2, "R9 wait-state cost", 32'(l4 - l0), 32'd2);
        park = 1'b0;
        do_op("R7", 0, 2, 0, 0, 'h54, 32'h0, 0, 0, 0, 0, l2);
        do_op("R7", 0, 2, 0, 0, 'h54, 32'h0, 0, 3, 0, 0, l3);
        chk(l3 - l2 == 12, "R7 three busy rounds re-arbitrated", 32'(l3 - l2), 32'd12);

        mism = 0;
        for (int i = 0; i < 64; i++) if (sl_mem[i] !== ref_mem[i]) mism++;
        chk(mism == 0, "R2 memory image after all writes", 32'(mism), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule